// File: doc/BRIEF.md
# Bus ECC Error Monitor

This block sits beside a memory controller and observes the result of each memory access that crosses the system bus. The memory's ECC logic reports every access as clean, correctable or uncorrectable, together with the access address and a single-bit qualifier. The first failing access is logged: its address and error type are held until software acknowledges it. Correctable and uncorrectable errors are counted separately, in saturating counters. Each count is compared with its own programmable threshold, and each comparison has its own enable. A companion scrubber can also report completion through a done pulse.

Software reaches the block through a small word-wide register port. There are three registers. Word 0 is status. Word 1 is the failing address and is read-only. Word 2 is threshold control. A status write replaces the whole register. Writing zero therefore acknowledges everything. Writing a counter field back with its current value keeps that counter, so software can acknowledge a logged error without losing a count that has not yet reached its threshold.

The log is a two-state machine with the states IDLE (nothing logged) and HELD (an error is logged). There are three named transitions. CAPTURE goes from IDLE to HELD when an error access arrives. SW_CLEAR goes from HELD to IDLE when software writes status with bit 0 clear. SW_SET goes from IDLE to HELD when software writes status with bit 0 set. In every other case the state is kept. The new-error flag is the HELD state itself.

Top module: `ecc_err_mon`

## Requirements
- R1: After reset, status, failing address and control all read zero, and `irq` is 0.
- R2: The error kinds are 2'b01 (correctable) and 2'b10 (uncorrectable). In state IDLE, such an access moves the log to HELD on the next clock edge. It then sets status bit 0, stores the address in word 1, sets bit 3 if the error was correctable, and copies `acc_single_bit` to bit 4.
- R3: While bit 0 is set, further error accesses leave word 1 and status bits 3 and 4 unchanged.
- R4: Each correctable access adds one to the count in status bits [8 +: CNT_W]. Each uncorrectable access adds one to the count in bits [16 +: CNT_W]. Kinds 2'b00 and 2'b11 change nothing.
- R5: A count at its all-ones value stays there on further errors.
- R6: Threshold fields sit in control [0 +: CNT_W] (correctable) and [8 +: CNT_W] (uncorrectable), with enables at bit 16 and bit 17. When an error moves a count to a value at or above its threshold and that threshold's enable is 1, status bit 1 (correctable) or bit 2 (uncorrectable) becomes set. That flag stays set until a status write. With the enable at 0, the flag is not set.
- R7: A status write loads every implemented status bit from the write data. Writing back a count field keeps that count. An error or done pulse in the same cycle as a status write is dropped.
- R8: A `scrub_done` pulse sets status bit 5.
- R9: `irq` is the OR of status bit 0, bit 5, bit 1 gated by its enable, and bit 2 gated by its enable.
- R10: Control (word 2) reads back what was written in its implemented bits. Writes to word 1 are ignored. Word 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_err_kind | input | 2 | Error result of this cycle's access (00 none, 01 correctable, 10 uncorrectable, 11 none) |
| acc_addr | input | ADDR_W | Address of this cycle's access |
| acc_single_bit | input | 1 | Error was a single-bit error |
| scrub_done | input | 1 | Scrubber completion pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with ADDR_W = 16 and CNT_W = 3. A count then saturates at 7 after a handful of errors, and small thresholds such as 1, 2 and 3 are reached within a few accesses, so both R5 and R6 are exercised in short runs. The narrow address keeps the logged-address comparisons readable. The default width is only a wider copy of the same datapath.

// File: rtl/ecc_mon_pkg.sv
`timescale 1ns/1ps
package ecc_mon_pkg;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'b00,
        ERR_CORR   = 2'b01,
        ERR_UNCORR = 2'b10,
        ERR_RSVD   = 2'b11
    } err_kind_e;

    typedef enum logic {
        LOG_IDLE = 1'b0,
        LOG_HELD = 1'b1
    } log_state_e;

    localparam int REG_AW = 2;

    // register word indices
    localparam logic [REG_AW-1:0] RA_STATUS = 2'd0;
    localparam logic [REG_AW-1:0] RA_FAIL   = 2'd1;
    localparam logic [REG_AW-1:0] RA_CTRL   = 2'd2;

    // status bit positions
    localparam int ST_NEW     = 0;
    localparam int ST_CE_THR  = 1;
    localparam int ST_UE_THR  = 2;
    localparam int ST_CORR    = 3;
    localparam int ST_SINGLE  = 4;
    localparam int ST_DONE    = 5;
    localparam int ST_CE_LSB  = 8;
    localparam int ST_UE_LSB  = 16;

    // control bit positions
    localparam int CT_CE_LSB  = 0;
    localparam int CT_UE_LSB  = 8;
    localparam int CT_CE_EN   = 16;
    localparam int CT_UE_EN   = 17;

    // counter slot indices
    localparam int SLOT_CE = 0;
    localparam int SLOT_UE = 1;
    localparam int N_SLOTS = 2;

endpackage

// File: rtl/ecc_mon_capture.sv
`timescale 1ns/1ps
module ecc_mon_capture
    import ecc_mon_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_hit,
    input  logic              err_corr,
    input  logic              err_single,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic              st_wr,
    input  logic              wr_new,
    input  logic              wr_corr,
    input  logic              wr_single,
    output logic              new_err,
    output logic [ADDR_W-1:0] fail_addr,
    output logic              log_corr,
    output logic              log_single
);

    log_state_e state_q, state_d;

    // next-state: CAPTURE, SW_CLEAR, SW_SET
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LOG_IDLE: begin
                if (st_wr) begin
                    if (wr_new) state_d = LOG_HELD;        // SW_SET
                end else if (err_hit) begin
                    state_d = LOG_HELD;                    // CAPTURE
                end
            end
            LOG_HELD: begin
                if (st_wr && !wr_new) state_d = LOG_IDLE;  // SW_CLEAR
            end
            default: state_d = LOG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LOG_IDLE;
        else        state_q <= state_d;
    end

    // logged data: loaded on CAPTURE, type bits replaced by status writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_addr  <= '0;
            log_corr   <= 1'b0;
            log_single <= 1'b0;
        end else if (st_wr) begin
            log_corr   <= wr_corr;
            log_single <= wr_single;
        end else if (state_q == LOG_IDLE && err_hit) begin
            fail_addr  <= err_addr;
            log_corr   <= err_corr;
            log_single <= err_single;
        end
    end

    assign new_err = (state_q == LOG_HELD);

endmodule

// File: rtl/ecc_mon_counter.sv
`timescale 1ns/1ps
module ecc_mon_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic [CNT_W-1:0] thr,
    input  logic             thr_en,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_cnt,
    input  logic             ld_flag,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_sat;

    always_comb begin
        if (cnt == CNT_MAX) cnt_sat = cnt;
        else                cnt_sat = cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else if (ld) begin
            cnt  <= ld_cnt;
            flag <= ld_flag;
        end else if (inc) begin
            cnt <= cnt_sat;
            if (thr_en && (cnt_sat >= thr)) flag <= 1'b1;
        end
    end

endmodule

// File: rtl/ecc_mon_regs.sv
`timescale 1ns/1ps
module ecc_mon_regs
    import ecc_mon_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic [31:0]       status_word,
    input  logic [ADDR_W-1:0] fail_addr,
    output logic [31:0]       reg_rdata,
    output logic              st_wr,
    output logic [CNT_W-1:0]  ce_thr,
    output logic [CNT_W-1:0]  ue_thr,
    output logic              ce_en,
    output logic              ue_en
);

    logic [31:0] fail_word;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_thr <= '0;
            ue_thr <= '0;
            ce_en  <= 1'b0;
            ue_en  <= 1'b0;
        end else if (reg_wr && reg_addr == RA_CTRL) begin
            ce_thr <= reg_wdata[CT_CE_LSB +: CNT_W];
            ue_thr <= reg_wdata[CT_UE_LSB +: CNT_W];
            ce_en  <= reg_wdata[CT_CE_EN];
            ue_en  <= reg_wdata[CT_UE_EN];
        end
    end

    assign st_wr = reg_wr && (reg_addr == RA_STATUS);

    always_comb begin
        fail_word = '0;
        fail_word[ADDR_W-1:0] = fail_addr;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_STATUS: reg_rdata = status_word;
            RA_FAIL:   reg_rdata = fail_word;
            RA_CTRL: begin
                reg_rdata[CT_CE_LSB +: CNT_W] = ce_thr;
                reg_rdata[CT_UE_LSB +: CNT_W] = ue_thr;
                reg_rdata[CT_CE_EN]           = ce_en;
                reg_rdata[CT_UE_EN]           = ue_en;
            end
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ecc_err_mon.sv
`timescale 1ns/1ps
module ecc_err_mon
    import ecc_mon_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        acc_err_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_single_bit,
    input  logic              scrub_done,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);

    logic              st_wr;
    logic              is_corr, is_uncorr, err_hit;
    logic              new_err, log_corr, log_single, done_q;
    logic [ADDR_W-1:0] fail_addr_w;
    logic [CNT_W-1:0]  ce_thr, ue_thr;
    logic              ce_en, ue_en;
    logic [31:0]       status_word;

    logic [CNT_W-1:0]  slot_cnt  [N_SLOTS];
    logic              slot_flag [N_SLOTS];
    logic              slot_inc  [N_SLOTS];
    logic [CNT_W-1:0]  slot_thr  [N_SLOTS];
    logic              slot_en   [N_SLOTS];
    logic [CNT_W-1:0]  slot_ldc  [N_SLOTS];
    logic              slot_ldf  [N_SLOTS];

    assign is_corr   = (err_kind_e'(acc_err_kind) == ERR_CORR);
    assign is_uncorr = (err_kind_e'(acc_err_kind) == ERR_UNCORR);
    assign err_hit   = is_corr || is_uncorr;

    ecc_mon_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .status_word (status_word),
        .fail_addr   (fail_addr_w),
        .reg_rdata   (reg_rdata),
        .st_wr       (st_wr),
        .ce_thr      (ce_thr),
        .ue_thr      (ue_thr),
        .ce_en       (ce_en),
        .ue_en       (ue_en)
    );

    ecc_mon_capture #(.ADDR_W(ADDR_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_hit    (err_hit),
        .err_corr   (is_corr),
        .err_single (acc_single_bit),
        .err_addr   (acc_addr),
        .st_wr      (st_wr),
        .wr_new     (reg_wdata[ST_NEW]),
        .wr_corr    (reg_wdata[ST_CORR]),
        .wr_single  (reg_wdata[ST_SINGLE]),
        .new_err    (new_err),
        .fail_addr  (fail_addr_w),
        .log_corr   (log_corr),
        .log_single (log_single)
    );

    // per-slot wiring: slot 0 correctable, slot 1 uncorrectable
    assign slot_inc[SLOT_CE] = is_corr;
    assign slot_thr[SLOT_CE] = ce_thr;
    assign slot_en [SLOT_CE] = ce_en;
    assign slot_ldc[SLOT_CE] = reg_wdata[ST_CE_LSB +: CNT_W];
    assign slot_ldf[SLOT_CE] = reg_wdata[ST_CE_THR];
    assign slot_inc[SLOT_UE] = is_uncorr;
    assign slot_thr[SLOT_UE] = ue_thr;
    assign slot_en [SLOT_UE] = ue_en;
    assign slot_ldc[SLOT_UE] = reg_wdata[ST_UE_LSB +: CNT_W];
    assign slot_ldf[SLOT_UE] = reg_wdata[ST_UE_THR];

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        ecc_mon_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (slot_inc[g]),
            .thr     (slot_thr[g]),
            .thr_en  (slot_en[g]),
            .ld      (st_wr),
            .ld_cnt  (slot_ldc[g]),
            .ld_flag (slot_ldf[g]),
            .cnt     (slot_cnt[g]),
            .flag    (slot_flag[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          done_q <= 1'b0;
        else if (st_wr)      done_q <= reg_wdata[ST_DONE];
        else if (scrub_done) done_q <= 1'b1;
    end

    always_comb begin
        status_word                          = '0;
        status_word[ST_NEW]                  = new_err;
        status_word[ST_CE_THR]               = slot_flag[SLOT_CE];
        status_word[ST_UE_THR]               = slot_flag[SLOT_UE];
        status_word[ST_CORR]                 = log_corr;
        status_word[ST_SINGLE]               = log_single;
        status_word[ST_DONE]                 = done_q;
        status_word[ST_CE_LSB +: CNT_W]      = slot_cnt[SLOT_CE];
        status_word[ST_UE_LSB +: CNT_W]      = slot_cnt[SLOT_UE];
    end

    assign irq = new_err || done_q
              || (slot_flag[SLOT_CE] && ce_en)
              || (slot_flag[SLOT_UE] && ue_en);

endmodule

// File: rtl/ecc_err_mon_chk.sv
`timescale 1ns/1ps
module ecc_err_mon_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        acc_err_kind,
    input logic              scrub_done,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       status_word,
    input logic [ADDR_W-1:0] fail_addr,
    input logic              ce_en
);

    localparam logic [31:0]      CNT_ONES = (32'd1 << CNT_W) - 32'd1;
    localparam logic [31:0]      ST_MASK  = 32'h3F | (CNT_ONES << 8) | (CNT_ONES << 16);
    localparam logic [CNT_W-1:0] CMAX     = '1;

    logic             wr_stat;
    logic [CNT_W-1:0] ce_c;
    logic             no_err;

    assign wr_stat = reg_wr && (reg_addr == 2'd0);
    assign ce_c    = status_word[8 +: CNT_W];
    assign no_err  = (acc_err_kind == 2'b00) || (acc_err_kind == 2'b11);

    AST_NO_SPURIOUS_LOG: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stat && !status_word[0] && no_err) |=> !status_word[0]); // R2

    AST_LOG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stat && status_word[0]) |=> ($stable(fail_addr) && $stable(status_word[4:3]))); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> ((ce_c == $past(ce_c)) || (ce_c == $past(ce_c) + 1'b1))); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stat && ce_c == CMAX) |=> (ce_c == CMAX)); // R5

    AST_THR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stat && !status_word[1] && !ce_en) |=> !status_word[1]); // R6

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> (status_word == ($past(reg_wdata) & ST_MASK))); // R7

    AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stat && scrub_done) |=> status_word[5]); // R8

endmodule

bind ecc_err_mon ecc_err_mon_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_err_kind (acc_err_kind),
    .scrub_done   (scrub_done),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .status_word  (status_word),
    .fail_addr    (fail_addr_w),
    .ce_en        (ce_en)
);

// File: tb/ecc_err_mon_test.sv
`timescale 1ns/1ps
module ecc_err_mon_test;

    localparam int AW = 16;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    acc_err_kind = 2'b00;
    logic [AW-1:0] acc_addr = '0;
    logic          acc_single_bit = 1'b0;
    logic          scrub_done = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ecc_err_mon #(.ADDR_W(AW), .CNT_W(CW)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .acc_err_kind   (acc_err_kind),
        .acc_addr       (acc_addr),
        .acc_single_bit (acc_single_bit),
        .scrub_done     (scrub_done),
        .reg_wr         (reg_wr),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .irq            (irq)
    );

    // {kind, single, addr, expected status, expected failing addr, expected irq}
    localparam logic [67:0] VEC [0:6] = '{
        {2'd1, 1'b1, 16'h1234, 32'h0000_0119, 16'h1234, 1'b1},
        {2'd0, 1'b0, 16'h5555, 32'h0000_0119, 16'h1234, 1'b1},
        {2'd2, 1'b0, 16'h2222, 32'h0001_0119, 16'h1234, 1'b1},
        {2'd3, 1'b1, 16'h3333, 32'h0001_0119, 16'h1234, 1'b1},
        {2'd1, 1'b0, 16'h4444, 32'h0001_0219, 16'h1234, 1'b1},
        {2'd1, 1'b0, 16'h4445, 32'h0001_031B, 16'h1234, 1'b1},
        {2'd2, 1'b1, 16'h4446, 32'h0002_031B, 16'h1234, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic acc(input logic [1:0] k, input logic [AW-1:0] a, input logic s);
        acc_err_kind = k; acc_addr = a; acc_single_bit = s;
        @(posedge clk); #1;
        acc_err_kind = 2'b00;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, d); check("R1 status", d, 32'h0);
        rd(2'd1, d); check("R1 fail addr", d, 32'h0);
        rd(2'd2, d); check("R1 control", d, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'h0);

        // R10 register access
        wr(2'd2, 32'h0001_0103);
        rd(2'd2, d); check("R10 control readback", d, 32'h0001_0103);
        wr(2'd1, 32'h0000_FFFF);
        rd(2'd1, d); check("R10 fail addr write ignored", d, 32'h0);
        rd(2'd3, d); check("R10 word3 zero", d, 32'h0);

        // table walk: R2 R3 R4 R6
        for (int i = 0; i < 7; i++) begin
            acc(VEC[i][67:66], VEC[i][64:49], VEC[i][65]);
            rd(2'd0, d); check($sformatf("R2/R3/R4/R6 vec%0d status", i), d, VEC[i][48:17]);
            rd(2'd1, d); check($sformatf("R3 vec%0d addr", i), d, {16'd0, VEC[i][16:1]});
            check($sformatf("R9 vec%0d irq", i), {31'd0, irq}, {31'd0, VEC[i][0]});
        end

        // R7 writeback keeps the correctable count only
        wr(2'd0, 32'h0000_0300);
        rd(2'd0, d); check("R7 writeback", d, 32'h0000_0300);
        check("R9 irq after clear", {31'd0, irq}, 32'h0);
        acc(2'd2, 16'h7777, 1'b0);
        rd(2'd0, d); check("R2 recapture status", d, 32'h0001_0301);
        rd(2'd1, d); check("R2 recapture addr", d, 32'h0000_7777);

        // R7 write wins over same-cycle error
        acc_err_kind = 2'd1; acc_addr = 16'h9999;
        wr(2'd0, 32'h0);
        acc_err_kind = 2'd0;
        rd(2'd0, d); check("R7 write wins status", d, 32'h0);
        rd(2'd1, d); check("R7 write wins addr", d, 32'h0000_7777);

        // R5 saturation
        for (int i = 0; i < 10; i++) acc(2'd1, 16'h0100 + 16'(i), 1'b0);
        rd(2'd0, d); check("R5 saturate", d, 32'h0000_070B);
        rd(2'd1, d); check("R3 first addr kept", d, 32'h0000_0100);

        // R6 disabled correctable threshold, enabled uncorrectable threshold
        wr(2'd2, 32'h0002_0201);
        wr(2'd0, 32'h0);
        acc(2'd1, 16'h0AAA, 1'b1);
        rd(2'd0, d); check("R6 ce disabled", d, 32'h0000_0119);
        acc(2'd2, 16'h0BBB, 1'b0);
        rd(2'd0, d); check("R6 ue below thr", d, 32'h0001_0119);
        acc(2'd2, 16'h0CCC, 1'b0);
        rd(2'd0, d); check("R6 ue reaches thr", d, 32'h0002_011D);

        // R9 irq gating by enable
        wr(2'd0, 32'h0);
        check("R9 irq cleared", {31'd0, irq}, 32'h0);
        wr(2'd0, 32'h0000_0004);
        check("R9 irq from ue flag", {31'd0, irq}, 32'h1);
        wr(2'd2, 32'h0000_0201);
        check("R9 irq masked", {31'd0, irq}, 32'h0);
        rd(2'd0, d); check("R9 flag kept", d, 32'h0000_0004);

        // R8 done
        wr(2'd0, 32'h0);
        scrub_done = 1'b1;
        @(posedge clk); #1;
        scrub_done = 1'b0;
        rd(2'd0, d); check("R8 done flag", d, 32'h0000_0020);
        check("R8 done irq", {31'd0, irq}, 32'h1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule